// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. It receives the accumulator (A) and the second working register (B), a 4-bit operation code, the carry flag stored by the processor, and an execute strobe. On the clock edge where the strobe is high, it registers the result byte, raises a write-back request for A for one cycle, and registers a zero flag and a carry/borrow flag.

The block covers nine operations: addition with and without carry, subtraction, increment, decrement, compare, and the bitwise AND, OR and XOR. Compare subtracts B from A only to set the flags and does not request a write to A. Because of this, a branch on "equal" or "not equal" is simply a test of the zero flag. A single shared adder does all the arithmetic. For the operations that take something away, the carry output is inverted so that the flag reads as a borrow. The register file, the instruction decoder and bus steering sit outside the block.

Top module: `acc_alu_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the result, the write-back request, the zero flag and the carry flag are all 0.
- R2: Op code 0 (add) registers A+B. Op code 1 (add with carry) registers A+B+carry_in. In both, the carry flag takes the carry out of bit 7.
- R3: Op code 2 (subtract) registers A-B, op code 3 (increment) registers A+1, and op code 4 (decrement) registers A-1, all modulo 256. The carry flag is the borrow for subtract (A<B) and for decrement (A=0), and the carry out for increment (A=0xFF).
- R4: Op codes 6, 7 and 8 register A AND B, A OR B and A XOR B respectively, and always clear the carry flag.
- R5: Op code 5 (compare) registers A-B and its flags (zero set when A equals B, carry set when A<B) but leaves the write-back request low.
- R6: After every valid operation, the zero flag is 1 exactly when the registered result byte is 0x00.
- R7: In a cycle where the execute strobe is low, the result and both flags hold their values, and the write-back request is 0 in the following cycle.
- R8: The write-back request is 1 in the one cycle after an executed op code 0-4 or 6-8, and 0 again in the cycle after that unless another such op executes.
- R9: Op codes 9 to 15 have no effect even when executed: the result and flags hold, and the write-back request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe; updates happen only on edges where it is high |
| op_i | input | 4 | Operation code (0 add, 1 add with carry, 2 sub, 3 inc, 4 dec, 5 cmp, 6 and, 7 or, 8 xor) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Stored carry flag, used by add with carry |
| result_o | output | 8 | Registered result byte |
| wr_a_o | output | 1 | One-cycle write-back request for A |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry/borrow flag |

## Verification
Some rules are checked by properties on every clock: that idle cycles keep the result and flags frozen, that compare and reserved codes never raise the write-back request, that the zero flag agrees with the result byte, that logic operations clear the carry, and that plain addition matches a wide sum. Other behaviour can only be shown by the directed scenarios. These cover the exact borrow semantics of subtract and decrement, wrap-around at 0xFF and 0x00, and the carry-in path of add with carry. They also cover the one-cycle shape of the write-back pulse and the fact that reserved codes keep the values left by an earlier operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD = 4'd0,
        ALU_ADC = 4'd1,
        ALU_SUB = 4'd2,
        ALU_INC = 4'd3,
        ALU_DEC = 4'd4,
        ALU_CMP = 4'd5,
        ALU_AND = 4'd6,
        ALU_OR  = 4'd7,
        ALU_XOR = 4'd8
    } alu_op_e;

    // Second adder input choice
    typedef enum logic [1:0] {
        OPB_B    = 2'd0,
        OPB_NOTB = 2'd1,
        OPB_ZERO = 2'd2,
        OPB_ONES = 2'd3
    } opb_sel_e;

    // Adder carry-in choice
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        LF_AND  = 2'd0,
        LF_OR   = 2'd1,
        LF_XOR  = 2'd2,
        LF_NONE = 2'd3
    } logic_fn_e;

    typedef struct packed {
        logic      valid;
        logic      is_arith;
        logic      writes_a;
        logic      borrow;
        opb_sel_e  opb;
        cin_sel_e  cin;
        logic_fn_e lfn;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c = '{valid: 1'b1, is_arith: 1'b1, writes_a: 1'b1, borrow: 1'b0,
              opb: OPB_B, cin: CIN_ZERO, lfn: LF_NONE};
        case (code)
            ALU_ADD: ;
            ALU_ADC: c.cin = CIN_FLAG;
            ALU_SUB: begin c.opb = OPB_NOTB; c.cin = CIN_ONE; c.borrow = 1'b1; end
            ALU_INC: begin c.opb = OPB_ZERO; c.cin = CIN_ONE; end
            ALU_DEC: begin c.opb = OPB_ONES; c.borrow = 1'b1; end
            ALU_CMP: begin
                c.opb = OPB_NOTB; c.cin = CIN_ONE; c.borrow = 1'b1; c.writes_a = 1'b0;
            end
            ALU_AND: begin c.is_arith = 1'b0; c.lfn = LF_AND; end
            ALU_OR:  begin c.is_arith = 1'b0; c.lfn = LF_OR;  end
            ALU_XOR: begin c.is_arith = 1'b0; c.lfn = LF_XOR; end
            default: begin c.valid = 1'b0; c.writes_a = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         flag_cin,
    input  opb_sel_e     opb,
    input  cin_sel_e     cin,
    input  logic         borrow,
    output logic [W-1:0] sum,
    output logic         cy
);
    logic [W-1:0] y;
    logic         c0;
    logic [W:0]   wide;

    always_comb begin
        case (opb)
            OPB_B:    y = b;
            OPB_NOTB: y = ~b;
            OPB_ZERO: y = '0;
            default:  y = '1;
        endcase
        case (cin)
            CIN_ONE:  c0 = 1'b1;
            CIN_FLAG: c0 = flag_cin;
            default:  c0 = 1'b0;
        endcase
        wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c0};
        sum  = wide[W-1:0];
        // subtract-type ops report a borrow, the inverse of carry-out
        cy   = borrow ? ~wide[W] : wide[W];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    lfn,
    output logic [W-1:0] y
);
    always_comb begin
        case (lfn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         wr_d,
    input  logic [W-1:0] res_d,
    input  logic         zero_d,
    input  logic         carry_d,
    output logic [W-1:0] res_q,
    output logic         wr_q,
    output logic         zero_q,
    output logic         carry_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            wr_q    <= 1'b0;
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            wr_q <= load & wr_d;
            if (load) begin
                res_q   <= res_d;
                zero_q  <= zero_d;
                carry_q <= carry_d;
            end
        end
    end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exec_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            carry_i,
    output logic [W-1:0]    result_o,
    output logic            wr_a_o,
    output logic            zero_o,
    output logic            carry_o
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] arith_y;
    logic         arith_cy;
    logic [W-1:0] logic_y;
    logic [W-1:0] res_d;
    logic         cy_d;

    assign ctrl = decode_op(op_i);

    acc_alu_arith #(.W(W)) arith_i (
        .a(a_i), .b(b_i), .flag_cin(carry_i),
        .opb(ctrl.opb), .cin(ctrl.cin), .borrow(ctrl.borrow),
        .sum(arith_y), .cy(arith_cy)
    );

    acc_alu_logic #(.W(W)) logic_i (
        .a(a_i), .b(b_i), .lfn(ctrl.lfn), .y(logic_y)
    );

    always_comb begin
        res_d = ctrl.is_arith ? arith_y : logic_y;
        cy_d  = ctrl.is_arith ? arith_cy : 1'b0;
    end

    acc_alu_flagreg #(.W(W)) flags_i (
        .clk(clk), .rst(rst),
        .load(exec_i & ctrl.valid),
        .wr_d(ctrl.writes_a),
        .res_d(res_d),
        .zero_d(~|res_d),
        .carry_d(cy_d),
        .res_q(result_o), .wr_q(wr_a_o),
        .zero_q(zero_o), .carry_q(carry_o)
    );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            exec_i,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic [W-1:0]    result_o,
    input logic            wr_a_o,
    input logic            zero_o,
    input logic            carry_o
);
    logic is_logic_op;
    logic is_valid_op;
    assign is_logic_op = (op_i == ALU_AND) || (op_i == ALU_OR) || (op_i == ALU_XOR);
    assign is_valid_op = (op_i <= 4'd8);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> (!wr_a_o && $stable(result_o) && $stable(zero_o) && $stable(carry_o)));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_i == ALU_CMP) |=> !wr_a_o);

    assert_cmp_equal_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_i == ALU_CMP && a_i == b_i) |=> (zero_o && !carry_o));

    assert_zero_matches_R6: assert property (@(posedge clk) disable iff (rst)
        (exec_i && is_valid_op) |=> (zero_o == (result_o == '0)));

    assert_logic_clears_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_i && is_logic_op) |=> !carry_o);

    assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_i == ALU_ADD) |=>
            ({carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

    assert_write_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (exec_i && is_valid_op && op_i != ALU_CMP) |=> wr_a_o);

    assert_reserved_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (exec_i && !is_valid_op) |=> (!wr_a_o && $stable(result_o) && $stable(zero_o) && $stable(carry_o)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !wr_a_o && !zero_o && !carry_o));
endmodule

bind acc_alu_top acc_alu_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_a_o(wr_a_o),
    .zero_o(zero_o), .carry_o(carry_o)
);

// File: tb/acc_alu_top_tb_top.sv
module acc_alu_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0;
    logic [7:0] b_i = 8'd0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic       wr_a_o;
    logic       zero_o;
    logic       carry_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // expected registered state
    logic [7:0] exp_res = 8'd0;
    logic       exp_z   = 1'b0;
    logic       exp_c   = 1'b0;

    always #5 clk = ~clk;

    acc_alu_top dut_i (
        .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
        .result_o(result_o), .wr_a_o(wr_a_o),
        .zero_o(zero_o), .carry_o(carry_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input logic exp_wr);
        check({tag, " result"}, int'(result_o), int'(exp_res));
        check({tag, " zero"},   int'(zero_o),   int'(exp_z));
        check({tag, " carry"},  int'(carry_o),  int'(exp_c));
        check({tag, " wr_a"},   int'(wr_a_o),   int'(exp_wr));
    endtask

    // apply one executed operation and check one cycle later
    task automatic run_op(input string tag, input logic [3:0] op,
                          input logic [7:0] a, input logic [7:0] b, input logic ci);
        int t;
        logic wr;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; carry_i = ci; exec_i = 1'b1;
        wr = 1'b1;
        case (op)
            4'd0: begin t = a + b;      exp_c = (t > 255); end
            4'd1: begin t = a + b + ci; exp_c = (t > 255); end
            4'd2: begin t = a - b;      exp_c = (a < b); end
            4'd3: begin t = a + 1;      exp_c = (a == 8'hFF); end
            4'd4: begin t = a - 1;      exp_c = (a == 8'h00); end
            4'd5: begin t = a - b;      exp_c = (a < b); wr = 1'b0; end
            4'd6: begin t = a & b;      exp_c = 1'b0; end
            4'd7: begin t = a | b;      exp_c = 1'b0; end
            4'd8: begin t = a ^ b;      exp_c = 1'b0; end
            default: begin t = exp_res; wr = 1'b0; end
        endcase
        exp_res = t[7:0];
        if (op <= 4'd8) exp_z = (exp_res == 8'h00);
        @(negedge clk);
        exec_i = 1'b0;
        check_state(tag, wr);
    endtask

    task automatic t_reset();
        check_state("R1 reset", 1'b0);
    endtask

    task automatic t_add();
        run_op("R2 add small",   4'd0, 8'h12, 8'h34, 1'b1);
        run_op("R2 add carry",   4'd0, 8'hF0, 8'h20, 1'b0);
        run_op("R6 add to zero", 4'd0, 8'h80, 8'h80, 1'b0);
        run_op("R2 adc cin",     4'd1, 8'h10, 8'h20, 1'b1);
        run_op("R2 adc no cin",  4'd1, 8'h10, 8'h20, 1'b0);
        run_op("R2 adc wrap",    4'd1, 8'hFF, 8'h00, 1'b1);
    endtask

    task automatic t_sub_inc_dec();
        run_op("R3 sub plain",  4'd2, 8'h50, 8'h20, 1'b1);
        run_op("R3 sub borrow", 4'd2, 8'h20, 8'h50, 1'b0);
        run_op("R3 inc",        4'd3, 8'h41, 8'h99, 1'b0);
        run_op("R3 inc wrap",   4'd3, 8'hFF, 8'h00, 1'b0);
        run_op("R3 dec wrap",   4'd4, 8'h00, 8'h07, 1'b0);
        run_op("R3 dec to 0",   4'd4, 8'h01, 8'h07, 1'b0);
    endtask

    task automatic t_logic();
        run_op("R4 setup carry", 4'd2, 8'h01, 8'h02, 1'b0);
        run_op("R4 and",         4'd6, 8'hF0, 8'h3C, 1'b1);
        run_op("R4 or",          4'd7, 8'h0F, 8'hA0, 1'b1);
        run_op("R4 xor same",    4'd8, 8'h5A, 8'h5A, 1'b1);
    endtask

    task automatic t_cmp();
        run_op("R5 cmp equal",   4'd5, 8'h33, 8'h33, 1'b0);
        run_op("R5 cmp less",    4'd5, 8'h10, 8'h20, 1'b0);
        run_op("R5 cmp greater", 4'd5, 8'h90, 8'h20, 1'b1);
    endtask

    task automatic t_idle();
        run_op("R8 add pulse", 4'd0, 8'h01, 8'h02, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            op_i = 4'(i); a_i = 8'hFF; b_i = 8'(i + 1); carry_i = 1'b1;
            @(negedge clk);
            check_state("R7 idle hold", 1'b0);
        end
    endtask

    task automatic t_reserved();
        run_op("R9 set state", 4'd2, 8'h05, 8'h09, 1'b0);
        for (int op = 9; op < 16; op++)
            run_op("R9 reserved", 4'(op), 8'h00, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub_inc_dec();
        t_logic();
        t_cmp();
        t_idle();
        t_reserved();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule